// File: doc/BRIEF.md
# LED Fault Detection Readout Sequencer

This block runs one LED fault check on a 24-channel constant-current driver and hands the outcome to the serial shift path as a parallel word. A request arrives as a one-cycle pulse with a two-bit kind, decoded upstream from the edge-count key on the serial interface. The kinds are open-circuit only, short-circuit only, and both together. After a request the block waits for all three per-color output enables (active low) to go low. It then requires them to stay low for a minimum number of clocks, set by a parameter that stands for the 1 µs analog settling time.

On the next clock with the enables still low, the block samples the per-channel comparator flags. It combines them with the latched channel on/off data, and strobes a 24-bit pass/fail word into the shift path. A 1 marks a good channel. The word is always packed red, then green, then blue, whatever order is used for display data. A channel that was off during the check reads as failed.

If an enable rises before the window is complete, the check is dropped without a strobe. The block also supplies each channel's short-circuit comparator with the threshold choice of its color while a short check is pending.

Top module: `led_fault_seq`

## Requirements
- R1: After reset `load_stb` is 0, `load_word` is all zeros and `cmp_hi_thr` is all zeros.
- R2: A request is taken only while idle, on a cycle with `req_valid` high. The `req_kind` encodings are 2'b01 open only, 2'b10 short only and 2'b11 both. Kind 2'b00 and any request made while a check is pending are ignored.
- R3: The window counts the consecutive clocks on which all three bits of `oe_n` are sampled low, starting with the first such clock after the request. `load_stb` rises for exactly one cycle after the (MIN_LOW_CYC+1)-th such clock and not before. While any `oe_n` bit stays high, no window starts.
- R4: If any `oe_n` bit is sampled high before the capture clock, the check is abandoned. There is no strobe, `load_word` keeps its value and the block returns to idle, ready for a new request.
- R5: In open-only mode a channel fails when its `open_flag` bit is 1, and `short_flag` has no effect.
- R6: In short-only mode a channel fails when its `short_flag` bit is 1, and `open_flag` has no effect.
- R7: In combined mode a channel fails when either of its flags is 1.
- R8: A channel whose `chan_on` bit is 0 reports 0 regardless of its flags.
- R9: Input vectors use index 8*c+k, where c is 0 for red, 1 for green and 2 for blue, and k+1 is the channel number. In `load_word`, red occupies bits 23:16, green 15:8 and blue 7:0. Within each byte, bit k is channel k+1. A result bit is 1 for good and 0 for failed.
- R10: While a short-only or combined check is pending, `cmp_hi_thr[8*c+k]` equals `thr_sel[c]`. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle check request |
| req_kind | input | 2 | Check kind: 01 open, 10 short, 11 both |
| oe_n | input | 3 | Per-color output enables, active low (0 red, 1 green, 2 blue) |
| chan_on | input | 24 | Latched channel on/off data |
| open_flag | input | 24 | Per-channel open-circuit comparator flags |
| short_flag | input | 24 | Per-channel short-circuit comparator flags |
| thr_sel | input | 3 | Per-color short threshold select (1 = higher threshold) |
| cmp_hi_thr | output | 24 | Per-channel threshold select to short comparators |
| load_word | output | 24 | Pass/fail word for the shift path |
| load_stb | output | 1 | One-cycle load strobe for `load_word` |

## Verification
The bench takes the request at one clock edge and drops the enables at the falling edge that follows. It then expects no strobe on the MIN_LOW_CYC falling edges after that. The strobe and the new word are due in the cycle after edge MIN_LOW_CYC+1, and the strobe must be gone one cycle later. The threshold select output is combinational from the pending state, so it is checked one cycle after the request edge. Abort, ignored-kind and one-enable-high cases watch every cycle of a window longer than the capture point to confirm that no strobe appears. The checks that `load_word` kept its value are made on those same cycles.

// File: rtl/led_fd_pkg.sv
package led_fd_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_OPEN  = 2'b01,
    KIND_SHORT = 2'b10,
    KIND_BOTH  = 2'b11
  } fd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ARMED  = 2'b01,
    ST_TIMING = 2'b10
  } fd_state_e;

endpackage

// File: rtl/led_fd_timer.sv
module led_fd_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !done) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT)); // R3

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/led_fd_eval.sv
module led_fd_eval #(
  parameter int unsigned COLORS = 3,
  parameter int unsigned CPC    = 8
) (
  input  logic                    chk_open,
  input  logic                    chk_short,
  input  logic                    thr_en,
  input  logic [COLORS*CPC-1:0]   chan_on,
  input  logic [COLORS*CPC-1:0]   open_flag,
  input  logic [COLORS*CPC-1:0]   short_flag,
  input  logic [COLORS-1:0]       thr_sel,
  output logic [COLORS*CPC-1:0]   good_word,
  output logic [COLORS*CPC-1:0]   hi_thr
);

  for (genvar c = 0; c < COLORS; c++) begin : g_color
    for (genvar k = 0; k < CPC; k++) begin : g_chan
      localparam int unsigned IN_IDX  = c * CPC + k;
      localparam int unsigned OUT_IDX = (COLORS - 1 - c) * CPC + k;
      logic fail;
      assign fail = (chk_open  & open_flag[IN_IDX]) |
                    (chk_short & short_flag[IN_IDX]);
      assign good_word[OUT_IDX] = chan_on[IN_IDX] & ~fail;
      assign hi_thr[IN_IDX]     = thr_en & thr_sel[c];
    end
  end

endmodule

// File: rtl/led_fault_seq.sv
module led_fault_seq #(
  parameter int unsigned MIN_LOW_CYC = 100,
  parameter int unsigned COLORS      = 3,
  parameter int unsigned CPC         = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [COLORS-1:0]      oe_n,
  input  logic [COLORS*CPC-1:0]  chan_on,
  input  logic [COLORS*CPC-1:0]  open_flag,
  input  logic [COLORS*CPC-1:0]  short_flag,
  input  logic [COLORS-1:0]      thr_sel,
  output logic [COLORS*CPC-1:0]  cmp_hi_thr,
  output logic [COLORS*CPC-1:0]  load_word,
  output logic                   load_stb
);
  import led_fd_pkg::*;

  localparam int unsigned W = COLORS * CPC;

  fd_state_e        state_q, state_d;
  fd_kind_e         kind_q, kind_d;
  logic             all_low;
  logic             win_done;
  logic             tmr_clr;
  logic             tmr_inc;
  logic             capture;
  logic             pending;
  logic [W-1:0]     good_word;
  logic [W-1:0]     word_q;
  logic             stb_q;

  assign all_low = (oe_n == '0);
  assign pending = (state_q != ST_IDLE);
  assign tmr_clr = (state_q == ST_IDLE);
  assign tmr_inc = all_low && pending;
  assign capture = (state_q == ST_TIMING) && all_low && win_done;

  led_fd_timer #(
    .LIMIT (MIN_LOW_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .inc   (tmr_inc),
    .done  (win_done)
  );

  led_fd_eval #(
    .COLORS (COLORS),
    .CPC    (CPC)
  ) u_eval (
    .chk_open   (kind_q[0]),
    .chk_short  (kind_q[1]),
    .thr_en     (pending && kind_q[1]),
    .chan_on    (chan_on),
    .open_flag  (open_flag),
    .short_flag (short_flag),
    .thr_sel    (thr_sel),
    .good_word  (good_word),
    .hi_thr     (cmp_hi_thr)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && (req_kind != KIND_NONE)) begin
          state_d = ST_ARMED;
          kind_d  = fd_kind_e'(req_kind);
        end
      end
      ST_ARMED: begin
        if (all_low) begin
          state_d = ST_TIMING;
        end
      end
      ST_TIMING: begin
        if (!all_low || win_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_NONE;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (capture) begin
      word_q <= good_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= capture;
    end
  end

  assign load_word = word_q;
  assign load_stb  = stb_q;

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb); // R3

  AST_STB_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(all_low)); // R3

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TIMING) && !all_low) |=> (!load_stb && $stable(load_word))); // R4

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TIMING) && !all_low) |=> (state_q == ST_IDLE)); // R4

  AST_OFF_READS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && ($past(chan_on) == '0)) |-> (load_word == '0)); // R8

  AST_THR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (cmp_hi_thr == '0)); // R10

  AST_BUSY_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && (state_d != ST_IDLE)) |=> $stable(kind_q)); // R2

endmodule

// File: tb/led_fault_seq_tb.sv
module led_fault_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MIN        = 40;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [2:0]  oe_n;
  logic [23:0] chan_on;
  logic [23:0] open_flag;
  logic [23:0] short_flag;
  logic [2:0]  thr_sel;
  logic [23:0] cmp_hi_thr;
  logic [23:0] load_word;
  logic        load_stb;

  int checks;
  int fails;

  led_fault_seq #(
    .MIN_LOW_CYC (MIN)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .oe_n       (oe_n),
    .chan_on    (chan_on),
    .open_flag  (open_flag),
    .short_flag (short_flag),
    .thr_sel    (thr_sel),
    .cmp_hi_thr (cmp_hi_thr),
    .load_word  (load_word),
    .load_stb   (load_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] exp_word(input logic [1:0] kind,
                                           input logic [23:0] on,
                                           input logic [23:0] op,
                                           input logic [23:0] sh);
    logic [23:0] w;
    w = '0;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic f;
        f = (kind[0] & op[8*c+k]) | (kind[1] & sh[8*c+k]);
        w[(2-c)*8+k] = on[8*c+k] & ~f;
      end
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    @(negedge clk);
    req_valid = 1'b0;
    req_kind  = 2'b00;
  endtask

  // Enables already low at this negedge; checks the strobe position and word.
  task automatic window_and_check(input string req, input logic [23:0] exp);
    int early;
    early = 0;
    for (int i = 0; i < MIN; i++) begin
      @(negedge clk);
      if (load_stb) early++;
    end
    chk({req, " no early strobe (R3)"}, 24'(early), 24'd0);
    @(negedge clk);
    chk({req, " strobe due (R3)"}, 24'(load_stb), 24'd1);
    chk({req, " word"}, load_word, exp);
    oe_n = 3'b111;
    @(negedge clk);
    chk({req, " strobe one cycle (R3)"}, 24'(load_stb), 24'd0);
  endtask

  task automatic run_check(input string req, input logic [1:0] kind,
                           input logic [23:0] on, input logic [23:0] op,
                           input logic [23:0] sh);
    chan_on = on; open_flag = op; short_flag = sh;
    issue(kind);
    oe_n = 3'b000;
    window_and_check(req, exp_word(kind, on, op, sh));
  endtask

  task automatic quiet_cycles(input string req, input int n, input logic [23:0] word_hold);
    int seen;
    int moved;
    seen = 0; moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (load_stb) seen++;
      if (load_word !== word_hold) moved++;
    end
    chk({req, " no strobe"}, 24'(seen), 24'd0);
    chk({req, " word held"}, 24'(moved), 24'd0);
  endtask

  task automatic t_reset;
    chk("R1 load_stb", 24'(load_stb), 24'd0);
    chk("R1 load_word", load_word, 24'd0);
    chk("R1 cmp_hi_thr", cmp_hi_thr, 24'd0);
  endtask

  task automatic t_modes;
    run_check("R5 open-only", 2'b01, 24'hFFFFFF, 24'h000301, 24'h810000);
    run_check("R6 short-only", 2'b10, 24'hFFFFFF, 24'h000301, 24'h810000);
    run_check("R7 combined", 2'b11, 24'hFFFFFF, 24'h000301, 24'h810000);
    run_check("R7 combined mixed", 2'b11, 24'hFFFFFF, 24'h5A0000, 24'h0000A5);
  endtask

  task automatic t_off_channels;
    run_check("R8 off channels", 2'b11, 24'h0F00F0, 24'h000000, 24'h000000);
  endtask

  task automatic t_packing;
    run_check("R9 red ch1 open", 2'b01, 24'hFFFFFF, 24'h000001, 24'h000000);
    chk("R9 red ch1 is bit 16", load_word, 24'hFEFFFF);
    run_check("R9 blue ch8 short", 2'b10, 24'hFFFFFF, 24'h000000, 24'h800000);
    chk("R9 blue ch8 is bit 7", load_word, 24'hFFFF7F);
  endtask

  task automatic t_abort;
    logic [23:0] held;
    held = load_word;
    chan_on = 24'h000000; open_flag = '0; short_flag = '0;
    issue(2'b11);
    oe_n = 3'b000;
    repeat (MIN / 2) @(negedge clk);
    oe_n = 3'b010;
    quiet_cycles("R4 abort", MIN + 5, held);
    oe_n = 3'b111;
    run_check("R4 new request after abort", 2'b01, 24'hFFFFFF, 24'h00FF00, 24'h0);
  endtask

  task automatic t_late_abort;
    logic [23:0] held;
    held = load_word;
    chan_on = 24'h0; open_flag = '0; short_flag = '0;
    issue(2'b01);
    oe_n = 3'b000;
    repeat (MIN) @(negedge clk);
    oe_n = 3'b100;
    quiet_cycles("R4 abort at capture clock", 5, held);
    oe_n = 3'b111;
  endtask

  task automatic t_one_high;
    logic [23:0] held;
    held = load_word;
    chan_on = 24'hFFFFFF; open_flag = 24'h000002; short_flag = '0;
    issue(2'b01);
    oe_n = 3'b001;
    quiet_cycles("R3 one enable high", MIN + 5, held);
    oe_n = 3'b000;
    window_and_check("R3 window after late start", exp_word(2'b01, 24'hFFFFFF, 24'h000002, 24'h0));
  endtask

  task automatic t_ignored;
    logic [23:0] held;
    held = load_word;
    issue(2'b00);
    oe_n = 3'b000;
    chk("R2 kind 00 no threshold", cmp_hi_thr, 24'h0);
    quiet_cycles("R2 kind 00 ignored", MIN + 5, held);
    oe_n = 3'b111;
    // request while pending: the second kind must not replace the first
    chan_on = 24'hFFFFFF; open_flag = 24'h0000F0; short_flag = 24'h0F0000;
    issue(2'b10);
    issue(2'b01);
    oe_n = 3'b000;
    window_and_check("R2 busy request ignored", exp_word(2'b10, 24'hFFFFFF, 24'h0000F0, 24'h0F0000));
  endtask

  task automatic t_threshold;
    thr_sel = 3'b101;
    issue(2'b10);
    chk("R10 short pending threshold", cmp_hi_thr, 24'hFF00FF);
    oe_n = 3'b000;
    window_and_check("R10 short run", exp_word(2'b10, chan_on, open_flag, short_flag));
    chk("R10 idle threshold cleared", cmp_hi_thr, 24'h0);
    issue(2'b01);
    chk("R10 open pending no threshold", cmp_hi_thr, 24'h0);
    oe_n = 3'b000;
    window_and_check("R10 open run", exp_word(2'b01, chan_on, open_flag, short_flag));
    thr_sel = 3'b010;
    issue(2'b11);
    chk("R10 combined pending threshold", cmp_hi_thr, 24'h00FF00);
    oe_n = 3'b000;
    window_and_check("R10 combined run", exp_word(2'b11, chan_on, open_flag, short_flag));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; oe_n = 3'b111;
    chan_on = '0; open_flag = '0; short_flag = '0; thr_sel = 3'b000;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_off_channels;
    t_packing;
    t_abort;
    t_late_abort;
    t_one_high;
    t_ignored;
    t_threshold;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule